// File: doc/BRIEF.md
# Hybrid Pointer-Vector Directory Set

This block holds one associative set of a coherence directory cache for a 16-node multicore. Six ways are narrow pointer entries: each holds a tag, one 4-bit owner node and a broadcast bit. Two ways are wide vector entries: each holds a tag and a 16-bit sharer mask. The set sits behind a request port that carries an operation, a line tag and the requesting node. The block matches the tag against every way and allocates an entry on a miss. It updates sharer tracking and reports the invalidations it needs as a registered node mask plus an all-nodes flag.

Most lines have a single owner, so they live in pointer ways. When a second node reads a line held in a pointer way, the line and a vector way trade places. The block picks the vector way in this order: a free one, then one with a single sharer, then the least recently touched one. If the chosen vector way still has several sharers, it is first shrunk to fit a pointer. A sharer count above a configurable threshold marks it as possibly shared by every node. A lower count keeps one sharer, picked at random, and invalidates the rest. The swap takes one extra cycle, during which new requests are held off.

Top module: `hpv_dir_set`

## Requirements
- R1: After reset every way is empty, `req_ready` is high and `inv_valid` is low. An evict of any tag then produces no invalidation.
- R2: A read (`req_op`=0) or write (`req_op`=1) that misses allocates a pointer entry owned by the requester, with no invalidation and no stall. An evict (`req_op`=2) that misses does nothing.
- R3: On a vector entry hit, a read adds the requester to the mask without invalidation. A write invalidates all other sharers and leaves the writer as sole sharer. An evict invalidates every sharer and frees the way.
- R4: A write to a pointer entry with the broadcast bit clear invalidates only the recorded owner, and none if the writer is the owner. The writer becomes the owner.
- R5: A write to a pointer entry with the broadcast bit set raises `inv_all` with a mask of every node except the writer. The entry then holds the writer as owner with the broadcast bit clear.
- R6: Evicting a pointer entry invalidates its owner when the broadcast bit is clear. When the bit is set, it invalidates all nodes with `inv_all` high. The way is freed.
- R7: A read of a pointer entry by a non-owner with the broadcast bit clear starts a swap. `req_ready` is low for exactly the cycle after acceptance. The line ends in a vector way whose mask is the old owner plus the reader.
- R8: A swap uses a free vector way first, then a vector way with exactly one sharer. The displaced single sharer moves into the pointer way as owner with no invalidation.
- R9: If both vector ways have several sharers, the swap displaces the vector way that was hit or filled less recently.
- R10: When the displaced vector's sharer count is greater than `cfg_thresh`, the pointer way receives it with the broadcast bit set and no invalidation is sent.
- R11: When the displaced vector's sharer count is at most `cfg_thresh`, one current sharer is kept as owner. All other sharers appear in the invalidation mask in the cycle after the swap cycle.
- R12: A pointer entry read by its owner, or read while its broadcast bit is set, changes nothing, sends no invalidation and causes no stall.
- R13: A miss with all six pointer ways in use replaces pointer ways in rotation starting from way 0. It emits the victim's eviction invalidation in the same way as R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | 5 | Sharer count above which a displaced vector is rounded up |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Set can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_tag | input | 8 | Line tag |
| req_node | input | 4 | Requesting node |
| inv_valid | output | 1 | Invalidation mask is non-empty |
| inv_mask | output | 16 | Nodes to invalidate |
| inv_all | output | 1 | Mask stems from a broadcast-marked entry |

## Verification
The bench targets the vector-way choice during a swap. It sets up a free way, a single-sharer way and two fully shared ways, and it changes which way was touched last. A wrong choice leaves the wrong line in pointer form, which a later evict exposes. The threshold is swept across the displaced sharer count. This catches an off-by-one comparison, which would broadcast where it should trim, or the reverse. The random trim is checked by set arithmetic: exactly one original sharer must survive, and that sharer must reappear when the line is evicted. Pointer rotation on a full set and broadcast writes that must spare the writer complete the set of cases.

// File: rtl/hpv_pkg.sv
package hpv_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_EVICT = 2'd2
   } op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SWAP = 1'b1
   } set_state_e;
endpackage

// File: rtl/hpv_lfsr.sv
module hpv_lfsr #(
   parameter int unsigned W = 4,
   parameter logic [W-1:0] TAPS = 4'b1100
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state_o
);
   if (W < 2) begin : g_bad_width
      $error("hpv_lfsr needs W >= 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_o <= W'(1);
      else        state_o <= {state_o[W-2:0], ^(state_o & TAPS)};
   end
endmodule

// File: rtl/hpv_sharer_reduce.sv
module hpv_sharer_reduce #(
   parameter int unsigned NODES  = 16,
   parameter int unsigned NODE_W = 4,
   parameter int unsigned CNT_W  = 5
) (
   input  logic [NODES-1:0]  vec_i,
   input  logic [NODE_W-1:0] rnd_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [NODE_W-1:0] lowest_o,
   output logic [NODE_W-1:0] pick_o
);
   always_comb begin
      count_o  = '0;
      lowest_o = '0;
      for (int i = NODES - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            count_o  = count_o + CNT_W'(1);
            lowest_o = NODE_W'(i);
         end
      end
      if (int'(rnd_i) < NODES && vec_i[rnd_i]) pick_o = rnd_i;
      else                                     pick_o = lowest_o;
   end
endmodule

// File: rtl/hpv_tag_match.sv
module hpv_tag_match #(
   parameter int unsigned N     = 6,
   parameter int unsigned TAG_W = 8,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]       valid_i,
   input  logic [N*TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]   key_i,
   output logic [N-1:0]       hit_o,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_o[i] = valid_i[i] && (tags_i[i*TAG_W +: TAG_W] == key_i);
   end

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_o[i]) idx_o = IDX_W'(i);
      end
   end
   assign any_o = |hit_o;
endmodule

// File: rtl/hpv_dir_set.sv
module hpv_dir_set
   import hpv_pkg::*;
#(
   parameter int unsigned NODES     = 16,
   parameter int unsigned NPTR      = 6,
   parameter int unsigned NVEC      = 2,
   parameter int unsigned TAG_W     = 8,
   parameter int unsigned THR_W     = 5,
   parameter int unsigned LFSR_TAPS = 'hC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [THR_W-1:0]         cfg_thresh,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [1:0]               req_op,
   input  logic [TAG_W-1:0]         req_tag,
   input  logic [$clog2(NODES)-1:0] req_node,
   output logic                     inv_valid,
   output logic [NODES-1:0]         inv_mask,
   output logic                     inv_all
);
   localparam int unsigned NODE_W = $clog2(NODES);
   localparam int unsigned CNT_W  = NODE_W + 1;
   localparam int unsigned PIDX_W = $clog2(NPTR);
   localparam int unsigned VIDX_W = (NVEC > 1) ? $clog2(NVEC) : 1;

   if (NVEC != 2) begin : g_bad_nvec
      $error("recency tracking supports exactly two vector ways");
   end
   if (NPTR < 2 || NODE_W < 2) begin : g_bad_size
      $error("need at least two pointer ways and four nodes");
   end

   op_e op;
   assign op = op_e'(req_op);

   // way storage
   logic [NPTR-1:0]   p_val;
   logic [TAG_W-1:0]  p_tag [NPTR];
   logic [NODE_W-1:0] p_own [NPTR];
   logic [NPTR-1:0]   p_bc;
   logic [NVEC-1:0]   v_val;
   logic [TAG_W-1:0]  v_tag [NVEC];
   logic [NODES-1:0]  v_vec [NVEC];
   logic [VIDX_W-1:0] mru;
   logic [PIDX_W-1:0] rr;

   set_state_e        state_q;
   logic [PIDX_W-1:0] sw_p;
   logic [VIDX_W-1:0] sw_v;
   logic [NODE_W-1:0] sw_node;

   logic [NODES-1:0]  inv_mask_q;
   logic              inv_all_q;

   // lookup
   logic [NPTR*TAG_W-1:0] p_tag_flat;
   logic [NVEC*TAG_W-1:0] v_tag_flat;
   logic [NPTR-1:0]   p_hit;
   logic [NVEC-1:0]   v_hit;
   logic              p_any, v_any;
   logic [PIDX_W-1:0] p_idx;
   logic [VIDX_W-1:0] v_idx;

   for (genvar i = 0; i < NPTR; i++) begin : g_pflat
      assign p_tag_flat[i*TAG_W +: TAG_W] = p_tag[i];
   end
   for (genvar i = 0; i < NVEC; i++) begin : g_vflat
      assign v_tag_flat[i*TAG_W +: TAG_W] = v_tag[i];
   end

   hpv_tag_match #(.N(NPTR), .TAG_W(TAG_W), .IDX_W(PIDX_W)) u_pmatch (
      .valid_i(p_val), .tags_i(p_tag_flat), .key_i(req_tag),
      .hit_o(p_hit), .any_o(p_any), .idx_o(p_idx));
   hpv_tag_match #(.N(NVEC), .TAG_W(TAG_W), .IDX_W(VIDX_W)) u_vmatch (
      .valid_i(v_val), .tags_i(v_tag_flat), .key_i(req_tag),
      .hit_o(v_hit), .any_o(v_any), .idx_o(v_idx));

   // random source and per-vector reductions
   logic [NODE_W-1:0] rnd;
   hpv_lfsr #(.W(NODE_W), .TAPS(LFSR_TAPS[NODE_W-1:0])) u_lfsr (
      .clk(clk), .rst_n(rst_n), .state_o(rnd));

   logic [CNT_W-1:0]  v_cnt  [NVEC];
   logic [NODE_W-1:0] v_low  [NVEC];
   logic [NODE_W-1:0] v_pick [NVEC];
   for (genvar i = 0; i < NVEC; i++) begin : g_red
      hpv_sharer_reduce #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_red (
         .vec_i(v_vec[i]), .rnd_i(rnd),
         .count_o(v_cnt[i]), .lowest_o(v_low[i]), .pick_o(v_pick[i]));
   end

   // free pointer way and swap target choice
   logic              p_free_any;
   logic [PIDX_W-1:0] p_free_idx;
   logic [VIDX_W-1:0] v_choice;
   logic              v_free_any, v_one_any;
   logic [VIDX_W-1:0] v_free_idx, v_one_idx;

   always_comb begin
      p_free_any = ~&p_val;
      p_free_idx = '0;
      for (int i = NPTR - 1; i >= 0; i--) begin
         if (!p_val[i]) p_free_idx = PIDX_W'(i);
      end
      v_free_any = 1'b0; v_free_idx = '0;
      v_one_any  = 1'b0; v_one_idx  = '0;
      for (int i = NVEC - 1; i >= 0; i--) begin
         if (!v_val[i]) begin
            v_free_any = 1'b1; v_free_idx = VIDX_W'(i);
         end
         if (v_val[i] && v_cnt[i] == CNT_W'(1)) begin
            v_one_any = 1'b1; v_one_idx = VIDX_W'(i);
         end
      end
      if (v_free_any)     v_choice = v_free_idx;
      else if (v_one_any) v_choice = v_one_idx;
      else                v_choice = ~mru;
   end

   logic [NODES-1:0] nbit, obit;
   logic             sw_start, sw_multi, sw_up;
   assign nbit     = NODES'(1) << req_node;
   assign obit     = NODES'(1) << p_own[p_idx];
   assign sw_start = (op == OP_READ) && !v_any && p_any && !p_bc[p_idx]
                     && (p_own[p_idx] != req_node);
   assign sw_multi = v_val[sw_v] && (v_cnt[sw_v] > CNT_W'(1));
   assign sw_up    = sw_multi && (int'(v_cnt[sw_v]) > int'(cfg_thresh));

   assign req_ready = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_val <= '0; p_bc <= '0; v_val <= '0;
         for (int i = 0; i < NPTR; i++) begin
            p_tag[i] <= '0; p_own[i] <= '0;
         end
         for (int i = 0; i < NVEC; i++) begin
            v_tag[i] <= '0; v_vec[i] <= '0;
         end
         mru <= '0; rr <= '0; state_q <= ST_IDLE;
         sw_p <= '0; sw_v <= '0; sw_node <= '0;
         inv_mask_q <= '0; inv_all_q <= 1'b0;
      end else begin
         inv_mask_q <= '0;
         inv_all_q  <= 1'b0;
         if (state_q == ST_SWAP) begin
            state_q        <= ST_IDLE;
            mru            <= sw_v;
            p_val[sw_p]    <= v_val[sw_v];
            p_tag[sw_p]    <= v_tag[sw_v];
            p_bc[sw_p]     <= sw_up;
            if (sw_multi && !sw_up) begin
               p_own[sw_p] <= v_pick[sw_v];
               inv_mask_q  <= v_vec[sw_v] & ~(NODES'(1) << v_pick[sw_v]);
            end else begin
               p_own[sw_p] <= v_low[sw_v];
            end
            v_val[sw_v] <= 1'b1;
            v_tag[sw_v] <= p_tag[sw_p];
            v_vec[sw_v] <= (NODES'(1) << p_own[sw_p]) | (NODES'(1) << sw_node);
         end else if (req_valid) begin
            if (v_any) begin
               mru <= v_idx;
               unique case (op)
                  OP_READ:  v_vec[v_idx] <= v_vec[v_idx] | nbit;
                  OP_WRITE: begin
                     v_vec[v_idx] <= nbit;
                     inv_mask_q   <= v_vec[v_idx] & ~nbit;
                  end
                  default: begin
                     v_val[v_idx] <= 1'b0;
                     v_vec[v_idx] <= '0;
                     inv_mask_q   <= v_vec[v_idx];
                  end
               endcase
            end else if (p_any) begin
               unique case (op)
                  OP_READ: if (sw_start) begin
                     state_q <= ST_SWAP;
                     sw_p    <= p_idx;
                     sw_v    <= v_choice;
                     sw_node <= req_node;
                  end
                  OP_WRITE: begin
                     if (p_bc[p_idx]) begin
                        inv_all_q  <= 1'b1;
                        inv_mask_q <= ~nbit;
                     end else begin
                        inv_mask_q <= obit & ~nbit;
                     end
                     p_own[p_idx] <= req_node;
                     p_bc[p_idx]  <= 1'b0;
                  end
                  default: begin
                     p_val[p_idx] <= 1'b0;
                     inv_all_q    <= p_bc[p_idx];
                     inv_mask_q   <= p_bc[p_idx] ? '1 : obit;
                  end
               endcase
            end else if (op != OP_EVICT) begin
               if (p_free_any) begin
                  p_val[p_free_idx] <= 1'b1;
                  p_tag[p_free_idx] <= req_tag;
                  p_own[p_free_idx] <= req_node;
                  p_bc[p_free_idx]  <= 1'b0;
               end else begin
                  inv_all_q  <= p_bc[rr];
                  inv_mask_q <= p_bc[rr] ? '1 : (NODES'(1) << p_own[rr]);
                  p_tag[rr]  <= req_tag;
                  p_own[rr]  <= req_node;
                  p_bc[rr]   <= 1'b0;
                  rr         <= (rr == PIDX_W'(NPTR - 1)) ? '0 : rr + PIDX_W'(1);
               end
            end
         end
      end
   end

   assign inv_mask  = inv_mask_q;
   assign inv_all   = inv_all_q;
   assign inv_valid = |inv_mask_q;

   // checks
   assert_unique_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({p_hit, v_hit}));

   assert_swap_single_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);

   assert_swap_raises_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && sw_start) |=> !req_ready);

   assert_miss_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !p_any && !v_any) |=> req_ready);

   assert_bcast_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |-> ($countones(inv_mask) >= NODES - 1));

   assert_trim_keeps_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SWAP && sw_multi && !sw_up)
      |=> ($countones(inv_mask) == int'($past(v_cnt[sw_v])) - 1));

   for (genvar i = 0; i < NVEC; i++) begin : g_vchk
      assert_vec_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
         v_val[i] |-> (v_vec[i] != '0));
   end
endmodule

// File: tb/hpv_dir_set_tb_top.sv
module hpv_dir_set_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  cfg_thresh;
   logic        req_valid;
   logic        req_ready;
   logic [1:0]  req_op;
   logic [7:0]  req_tag;
   logic [3:0]  req_node;
   logic        inv_valid;
   logic [15:0] inv_mask;
   logic        inv_all;

   int n_cmp = 0;
   int n_bad = 0;
   logic        s_vld, s_all, s_rdy;
   logic [15:0] s_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   hpv_dir_set dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_tag(req_tag), .req_node(req_node),
      .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_all(inv_all));

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic sample();
      s_vld = inv_valid; s_mask = inv_mask; s_all = inv_all; s_rdy = req_ready;
   endtask

   task automatic issue(input logic [1:0] op, input logic [7:0] tag, input int node);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_tag = tag; req_node = 4'(node);
      @(negedge clk);
      req_valid = 1'b0;
      sample();
   endtask

   task automatic tick();
      @(negedge clk);
      sample();
   endtask

   task automatic do_reset(input int thr);
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; cfg_thresh = 5'(thr);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // read by a then b: allocate pointer, then swap into a vector way
   task automatic build_pair(input logic [7:0] tag, input int a, input int b);
      issue(RD, tag, a);
      issue(RD, tag, b);
      tick();
   endtask

   function automatic logic [15:0] nb(input int n);
      return 16'(1) << n;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      req_valid = 1'b0; req_op = RD; req_tag = '0; req_node = '0;
      cfg_thresh = '0; rst_n = 1'b0;

      // R1 reset state
      do_reset(1);
      @(negedge clk); sample();
      check("R1 ready after reset", 32'(s_rdy), 32'd1);
      check("R1 no inv after reset", 32'(s_vld), 32'd0);
      issue(EV, 8'h99, 3);
      check("R1 evict on empty set", 32'(s_vld), 32'd0);

      // R2 / R6 sweep over every node
      for (int n = 0; n < 16; n++) begin
         issue(RD, 8'(8'h10 + n), n);
         check("R2 miss alloc no inv", {15'd0, s_vld, s_rdy}, 32'd1);
         issue(EV, 8'(8'h10 + n), n);
         check("R6 evict owner mask", {15'd0, s_all, s_mask}, 32'(nb(n)));
      end

      // R4 pointer write, broadcast bit clear
      issue(WR, 8'h20, 3);
      check("R2 write miss no inv", 32'(s_vld), 32'd0);
      issue(WR, 8'h20, 3);
      check("R4 owner rewrite no inv", 32'(s_vld), 32'd0);
      issue(WR, 8'h20, 9);
      check("R4 inv old owner", {15'd0, s_all, s_mask}, 32'(nb(3)));
      issue(EV, 8'h20, 0);
      check("R4 writer now owner", 32'(s_mask), 32'(nb(9)));

      // R12 owner reread
      issue(RD, 8'h21, 3);
      issue(RD, 8'h21, 3);
      check("R12 owner read no stall", {15'd0, s_vld, s_rdy}, 32'd1);
      issue(EV, 8'h21, 3);
      check("R12 owner unchanged", 32'(s_mask), 32'(nb(3)));

      // R7 / R3 swap into free vector, then vector ops
      issue(RD, 8'h30, 1);
      issue(RD, 8'h30, 5);
      check("R7 busy after swap accept", {15'd0, s_vld, s_rdy}, 32'd0);
      tick();
      check("R7 ready after swap", {15'd0, s_vld, s_rdy}, 32'd1);
      issue(RD, 8'h30, 7);
      check("R3 vector read no inv", {15'd0, s_vld, s_rdy}, 32'd1);
      issue(EV, 8'h30, 7);
      check("R3 vector evict all sharers", {15'd0, s_all, s_mask}, 32'(nb(1) | nb(5) | nb(7)));
      build_pair(8'h31, 2, 4);
      issue(WR, 8'h31, 4);
      check("R3 vector write inv others", 32'(s_mask), 32'(nb(2)));
      issue(EV, 8'h31, 4);
      check("R3 writer sole sharer", 32'(s_mask), 32'(nb(4)));

      // R8 single-sharer vector reused
      do_reset(1);
      build_pair(8'h40, 0, 1);
      build_pair(8'h41, 2, 3);
      issue(WR, 8'h40, 1);
      check("R3 write inv node0", 32'(s_mask), 32'(nb(0)));
      issue(RD, 8'h42, 4);
      issue(RD, 8'h42, 5);
      tick();
      check("R8 single sharer swap no inv", {15'd0, s_vld, s_rdy}, 32'd1);
      issue(EV, 8'h40, 0);
      check("R8 displaced line as pointer", {15'd0, s_all, s_mask}, 32'(nb(1)));
      issue(EV, 8'h42, 0);
      check("R8 new line in vector", 32'(s_mask), 32'(nb(4) | nb(5)));
      issue(EV, 8'h41, 0);
      check("R8 other vector intact", 32'(s_mask), 32'(nb(2) | nb(3)));

      // R9 / R10 / R6 round up, older vector displaced
      do_reset(1);
      build_pair(8'h50, 0, 1);
      build_pair(8'h51, 2, 3);
      issue(RD, 8'h52, 4);
      issue(RD, 8'h52, 5);
      tick();
      check("R10 round up no inv", {15'd0, s_vld, s_rdy}, 32'd1);
      issue(RD, 8'h50, 9);
      check("R12 bcast read no stall", {15'd0, s_vld, s_rdy}, 32'd1);
      issue(EV, 8'h50, 0);
      check("R6 bcast evict all nodes", {15'd0, s_all, s_mask}, {15'd0, 1'b1, 16'hFFFF});
      issue(EV, 8'h51, 0);
      check("R9 newer vector kept", 32'(s_mask), 32'(nb(2) | nb(3)));

      // R9 / R5 recency changed by a hit
      do_reset(1);
      build_pair(8'h60, 0, 1);
      build_pair(8'h61, 2, 3);
      issue(RD, 8'h60, 6);
      issue(RD, 8'h62, 4);
      issue(RD, 8'h62, 5);
      tick();
      issue(WR, 8'h61, 9);
      check("R5 bcast write all but writer", {15'd0, s_all, s_mask}, {15'd0, 1'b1, 16'hFDFF});
      issue(EV, 8'h61, 0);
      check("R5 writer sole owner", {15'd0, s_all, s_mask}, 32'(nb(9)));
      issue(EV, 8'h60, 0);
      check("R9 touched vector kept", 32'(s_mask), 32'(nb(0) | nb(1) | nb(6)));

      // R10 / R11 threshold sweep around a count of three
      for (int t = 0; t < 6; t++) begin
         logic [15:0] kept;
         do_reset(t);
         build_pair(8'h70, 0, 1);
         issue(RD, 8'h70, 2);
         build_pair(8'h71, 3, 4);
         issue(RD, 8'h71, 5);
         issue(RD, 8'h72, 6);
         issue(RD, 8'h72, 7);
         tick();
         if (3 > t) begin
            check("R10 count above thr no inv", 32'(s_vld), 32'd0);
            issue(EV, 8'h70, 0);
            check("R10 rounded up evict", {15'd0, s_all, s_mask}, {15'd0, 1'b1, 16'hFFFF});
         end else begin
            kept = 16'h0007 & ~s_mask;
            check("R11 trim inv two sharers", 32'($countones(s_mask)), 32'd2);
            check("R11 trim inv within sharers", 32'(s_mask & 16'hFFF8), 32'd0);
            check("R11 one sharer kept", 32'($countones(kept)), 32'd1);
            issue(EV, 8'h70, 0);
            check("R11 kept sharer is owner", {15'd0, s_all, s_mask}, 32'(kept));
         end
      end

      // R13 rotation when pointer ways are full
      do_reset(1);
      for (int k = 0; k < 6; k++) begin
         issue(RD, 8'(8'h80 + k), k);
         check("R2 fill pointer ways", 32'(s_vld), 32'd0);
      end
      issue(RD, 8'h86, 8);
      check("R13 first victim way0", {15'd0, s_all, s_mask}, 32'(nb(0)));
      issue(RD, 8'h87, 9);
      check("R13 second victim way1", 32'(s_mask), 32'(nb(1)));
      issue(EV, 8'h80, 0);
      check("R13 victim gone", 32'(s_vld), 32'd0);
      issue(EV, 8'h86, 0);
      check("R13 replacement tracked", 32'(s_mask), 32'(nb(8)));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule